// File: doc/BRIEF.md
# Watchdog Timer with Power-Good Gated Reset Pulse

This block supervises a host processor and produces the board's system reset pulse. Everything is timed by a one-millisecond strobe (`tick`). The host proves it is alive by toggling a watchdog input pin, or by writing a kick strobe. If no kick arrives within the programmed window, the block does one of two things, selected by configuration: it raises a dedicated watchdog-expired pin, or it fires the system reset pulse. After power-up, a separate initial wait, scaled in powers of two, gives the host time to boot before the first window starts.

The reset generator watches a group of power-good inputs chosen by a select mask. Once every selected input is true, it waits a programmable number of ticks. It then drives a reset pulse whose width is chosen on a logarithmic scale. If the group loses power-good before the pulse fires, the wait starts again from zero. If the group loses power-good after the pulse, the generator re-arms and pulses again the next time the group comes good.

Top module: `wdt_rst_gen`

## Requirements
- R1: While `rst_n` is low and right after it is released, `wdo` and `rst_out` are both 0.
- R2: With `tick` high every cycle, `rst_out` rises on the (D+1)-th clock edge after all inputs selected by `pg_sel` are 1. D is `cfg_dly`. Unselected inputs are ignored, and an all-zero `pg_sel` counts as good at once.
- R3: If any selected power-good input goes low before the pulse, the delay restarts from zero once the group is good again. If it goes low after the pulse, a new pulse follows the next time the group is good.
- R4: The pulse lasts 2^(k-1) ticks for `cfg_pw` = k in 1..16. Codes above 16 act as 16 (32768 ticks). Code 0 produces no pulse.
- R5: A window lasts `cfg_tmo`*10 ticks. Each edge of `wdi` restarts it, acting on the third clock edge after the change because of a two-flop synchronizer. A `sw_kick` high for one cycle restarts it at the next edge.
- R6: After reset, an initial wait precedes the first window. For `cfg_init` = k in 1..15 the wait is 100*2^(k-1) ticks; for 0 there is no wait. A kick during the wait starts the window at once.
- R7: With `cfg_tmo_rst`=0, a time-out raises `wdo`. It stays high until a kick, and it is low after the edge that takes the kick.
- R8: With `cfg_tmo_rst`=1, a time-out fires a reset pulse (while the power-good group is good and no pulse is running) and `wdo` stays 0. No further pulse follows until a kick starts a new window.
- R9: `cfg_tmo` = 0 disables the time-out: `wdo` never rises.
- R10: All delay, wait, window and pulse counts advance only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-millisecond time-base strobe |
| wdi | input | 1 | Asynchronous watchdog input; each edge is a kick |
| sw_kick | input | 1 | Kick strobe from the register side |
| cfg_tmo | input | 8 | Window length in 10-tick steps, 0 disables |
| cfg_init | input | 4 | Log-scaled initial wait code |
| cfg_tmo_rst | input | 1 | 1: time-out fires reset pulse, 0: raises wdo |
| cfg_pw | input | 5 | Log-scaled reset pulse width code |
| cfg_dly | input | 16 | Ticks from power-good to reset pulse |
| pg_in | input | PG_N | Power-good inputs |
| pg_sel | input | PG_N | Mask of power-good inputs that gate the pulse |
| wdo | output | 1 | Watchdog expired pin |
| rst_out | output | 1 | System reset pulse, active high |

## Verification
The power-good path is driven with unselected inputs already high, with a one-cycle dropout in the middle of the delay, and with a dropout after the pulse. These patterns separate masking, restart of the delay and re-arming. The watchdog is kicked through rising and falling `wdi` edges and through the strobe. The measured latencies of 3 and 1 cycles separate the synchronized path from the direct one, and periodic kicks show that the window never expires. Width and wait codes at 0, at low values and past the top of the range check the log mapping and its clamp. A test that holds `tick` low separates tick-gated counting from cycle counting.

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen #(
  parameter int PG_N      = 4,
  parameter int DLY_W     = 16,
  parameter int INIT_BASE = 100,
  parameter int TMO_STEP  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wdi,
  input  logic             sw_kick,
  input  logic [7:0]       cfg_tmo,
  input  logic [3:0]       cfg_init,
  input  logic             cfg_tmo_rst,
  input  logic [4:0]       cfg_pw,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic [PG_N-1:0]  pg_in,
  input  logic [PG_N-1:0]  pg_sel,
  output logic             wdo,
  output logic             rst_out
);
  localparam int WCW = $clog2(INIT_BASE * (2 ** 14) + 1);
  localparam int RCW = (DLY_W > 17) ? DLY_W : 17;

  typedef enum logic [1:0] {W_INIT, W_RUN, W_EXP} wst_t;
  typedef enum logic [1:0] {R_WAIT, R_DLY, R_ARM, R_PULSE} rst_t;

  logic [2:0]     wsync;
  logic           kick, in_run, wd_hit, wd_fire, all_good;
  wst_t           wst;
  rst_t           rs_st;
  logic [WCW-1:0] wd_cnt, init_len, tmo_len;
  logic [RCW-1:0] rs_cnt, pw_len;
  logic [4:0]     pw_code;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wsync <= '0;
    else        wsync <= {wsync[1:0], wdi};

  assign kick     = (wsync[2] ^ wsync[1]) | sw_kick;
  assign init_len = (cfg_init == '0) ? '0 : (WCW'(INIT_BASE) << (cfg_init - 4'd1));
  assign tmo_len  = WCW'(cfg_tmo) * WCW'(TMO_STEP);
  assign in_run   = (wst == W_RUN) || (wst == W_INIT && init_len == '0);
  assign wd_hit   = in_run && !kick && tick && (cfg_tmo != '0) &&
                    ((wd_cnt + WCW'(1)) >= tmo_len);
  assign wd_fire  = wd_hit && cfg_tmo_rst;
  assign wdo      = (wst == W_EXP) && !cfg_tmo_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wst <= W_INIT; wd_cnt <= '0;
    end else if (kick) begin
      wst <= W_RUN; wd_cnt <= '0;
    end else if (wd_hit) begin
      wst <= W_EXP; wd_cnt <= '0;
    end else if (in_run) begin
      wst <= W_RUN;
      if (tick && cfg_tmo != '0) wd_cnt <= wd_cnt + WCW'(1);
    end else if (wst == W_INIT && tick) begin
      if ((wd_cnt + WCW'(1)) >= init_len) begin
        wst <= W_RUN; wd_cnt <= '0;
      end else wd_cnt <= wd_cnt + WCW'(1);
    end

  assign all_good = &(pg_in | ~pg_sel);
  assign pw_code  = (cfg_pw > 5'd16) ? 5'd16 : cfg_pw;
  assign pw_len   = (pw_code == '0) ? '0 : (RCW'(1) << (pw_code - 5'd1));
  assign rst_out  = (rs_st == R_PULSE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs_st <= R_WAIT; rs_cnt <= '0;
    end else begin
      case (rs_st)
        R_WAIT:
          if (all_good) begin
            rs_cnt <= '0;
            if (cfg_dly == '0) rs_st <= (pw_len != '0) ? R_PULSE : R_ARM;
            else               rs_st <= R_DLY;
          end
        R_DLY:
          if (!all_good) begin
            rs_st <= R_WAIT; rs_cnt <= '0;
          end else if (tick) begin
            if ((rs_cnt + RCW'(1)) >= RCW'(cfg_dly)) begin
              rs_st <= (pw_len != '0) ? R_PULSE : R_ARM; rs_cnt <= '0;
            end else rs_cnt <= rs_cnt + RCW'(1);
          end
        R_ARM:
          if (!all_good) begin
            rs_st <= R_WAIT; rs_cnt <= '0;
          end else if (wd_fire) begin
            rs_st <= (pw_len != '0) ? R_PULSE : R_ARM; rs_cnt <= '0;
          end
        default:
          if (tick) begin
            if ((rs_cnt + RCW'(1)) >= pw_len) begin
              rs_st <= R_ARM; rs_cnt <= '0;
            end else rs_cnt <= rs_cnt + RCW'(1);
          end
      endcase
    end

  // R2
  pulse_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(all_good));
  // R4
  zero_width_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(cfg_pw) != '0);
  // R7
  kick_clears_wdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wdo);
  // R9
  wdo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdo) && $stable(cfg_tmo_rst) |-> $past(tick) && $past(cfg_tmo) != '0);
endmodule

// File: tb/test_wdt_rst_gen.sv
module test_wdt_rst_gen;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, tick = 1, wdi = 0, sw_kick = 0, cfg_tmo_rst = 0;
  logic [7:0] cfg_tmo = 3;
  logic [3:0] cfg_init = 0;
  logic [4:0] cfg_pw = 3;
  logic [15:0] cfg_dly = 0;
  logic [3:0] pg_in = 0, pg_sel = 0;
  logic wdo, rst_out;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt_rst_gen i_wdt_rst_gen (.clk(clk), .rst_n(rst_n), .tick(tick), .wdi(wdi),
    .sw_kick(sw_kick), .cfg_tmo(cfg_tmo), .cfg_init(cfg_init), .cfg_tmo_rst(cfg_tmo_rst),
    .cfg_pw(cfg_pw), .cfg_dly(cfg_dly), .pg_in(pg_in), .pg_sel(pg_sel),
    .wdo(wdo), .rst_out(rst_out));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    rst_n = 0; wdi = 0; sw_kick = 0; tick = 1;
    step(3);
    rst_n = 1;
  endtask

  task automatic sw_pulse();
    sw_kick = 1; @(negedge clk); sw_kick = 0;
  endtask

  task automatic wait_wdo(input logic lvl, input int max, output int n);
    n = 0;
    while (wdo !== lvl && n < max) begin @(negedge clk); n++; end
  endtask

  task automatic meas_pulse(input int max, output int start, output int width);
    start = 0; width = 0;
    while (rst_out !== 1'b1 && start < max) begin @(negedge clk); start++; end
    while (rst_out === 1'b1) begin @(negedge clk); width++; end
  endtask

  task automatic t_reset();
    pg_sel = 4'b0011; pg_in = 0; cfg_dly = 20;
    rst_n = 0; step(2);
    chk("R1 wdo in reset", wdo, 0);
    chk("R1 rst_out in reset", rst_out, 0);
    rst_n = 1;
    chk("R1 wdo after release", wdo, 0);
    step(5);
    chk("R2 no pulse without pg", rst_out, 0);
  endtask

  task automatic t_poweron();
    int s, w;
    cfg_dly = 20; cfg_pw = 3; pg_sel = 4'b0011; pg_in = 4'b0100; cfg_tmo = 0;
    apply_reset(); step(10);
    chk("R2 unselected pg ignored", rst_out, 0);
    pg_in = 4'b0111;
    meas_pulse(100, s, w);
    chk("R2 delay D+1", s, 21);
    chk("R4 width code3", w, 4);
    pg_sel = 0; pg_in = 0; cfg_dly = 5;
    apply_reset();
    meas_pulse(100, s, w);
    chk("R2 empty mask good at once", s, 6);
  endtask

  task automatic t_pgdrop();
    int s, w;
    cfg_dly = 20; cfg_pw = 3; pg_sel = 4'b0011; pg_in = 0; cfg_tmo = 0;
    apply_reset(); step(2);
    pg_in = 4'b0011; step(10);
    pg_in = 4'b0010; step(1);
    pg_in = 4'b0011;
    meas_pulse(100, s, w);
    chk("R3 delay restarts after dropout", s, 21);
    step(3);
    pg_in = 4'b0001; step(2);
    chk("R3 no pulse while pg low", rst_out, 0);
    pg_in = 4'b0011;
    meas_pulse(100, s, w);
    chk("R3 re-arm after pulse", s, 21);
  endtask

  task automatic t_width();
    int s, w;
    pg_sel = 0; cfg_dly = 0; cfg_tmo = 0;
    cfg_pw = 0; apply_reset(); meas_pulse(50, s, w);
    chk("R4 code0 no pulse", w, 0);
    cfg_pw = 1; apply_reset(); meas_pulse(50, s, w);
    chk("R4 code1 width", w, 1);
    cfg_pw = 5; apply_reset(); meas_pulse(50, s, w);
    chk("R4 code5 width", w, 16);
    cfg_pw = 20; apply_reset(); meas_pulse(50, s, w);
    chk("R4 code20 clamps to 32768", w, 32768);
  endtask

  task automatic t_wd_pin();
    int n;
    int hi;
    pg_sel = 0; cfg_dly = 0; cfg_pw = 0; cfg_init = 0; cfg_tmo = 3; cfg_tmo_rst = 0;
    apply_reset();
    wait_wdo(1, 200, n); chk("R5 window 30 ticks", n, 30);
    step(50); chk("R7 wdo held until kick", wdo, 1);
    wdi = 1;
    wait_wdo(0, 20, n); chk("R5 rising wdi kick latency", n, 3);
    wait_wdo(1, 200, n); chk("R5 window after wdi kick", n + 3, 33);
    sw_pulse();
    chk("R7 sw kick clears wdo", wdo, 0);
    wait_wdo(1, 200, n); chk("R5 window after sw kick", n, 30);
    wdi = 0;
    wait_wdo(0, 20, n); chk("R5 falling wdi kick latency", n, 3);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 20; j++) begin @(negedge clk); if (wdo) hi++; end
      sw_pulse();
    end
    chk("R5 periodic kicks keep wdo low", hi, 0);
  endtask

  task automatic t_init();
    int n;
    pg_sel = 0; cfg_pw = 0; cfg_tmo = 3; cfg_tmo_rst = 0;
    cfg_init = 1; apply_reset();
    wait_wdo(1, 1000, n); chk("R6 init code1", n, 130);
    cfg_init = 2; apply_reset();
    wait_wdo(1, 1000, n); chk("R6 init code2", n, 230);
    apply_reset(); step(20); sw_pulse();
    wait_wdo(1, 1000, n); chk("R6 kick ends initial wait", n, 30);
  endtask

  task automatic t_wd_reset();
    int s, w, hi;
    pg_sel = 0; cfg_dly = 0; cfg_pw = 3; cfg_init = 0; cfg_tmo = 3; cfg_tmo_rst = 1;
    apply_reset(); step(10);
    hi = 0;
    s = 0;
    while (!rst_out && s < 100) begin @(negedge clk); s++; if (wdo) hi++; end
    w = 0;
    while (rst_out) begin @(negedge clk); w++; end
    chk("R8 time-out fires pulse", s + 10, 30);
    chk("R8 pulse width", w, 4);
    chk("R8 wdo stays low", hi, 0);
    meas_pulse(100, s, w);
    chk("R8 no repeat before kick", w, 0);
    sw_pulse();
    meas_pulse(100, s, w);
    chk("R8 new window after kick", s, 30);
    cfg_pw = 0; sw_pulse();
    meas_pulse(60, s, w);
    chk("R8 width code0 no pulse", w, 0);
    cfg_tmo_rst = 0;
  endtask

  task automatic t_disable();
    int n;
    pg_sel = 0; cfg_pw = 0; cfg_init = 0; cfg_tmo = 0; cfg_tmo_rst = 0;
    apply_reset();
    wait_wdo(1, 300, n); chk("R9 code0 never expires", wdo, 0);
  endtask

  task automatic t_tick();
    int n, s, w;
    pg_sel = 0; cfg_pw = 0; cfg_init = 0; cfg_tmo = 3; cfg_tmo_rst = 0;
    apply_reset(); tick = 0;
    step(200); chk("R10 no window without tick", wdo, 0);
    tick = 1;
    wait_wdo(1, 200, n); chk("R10 window resumes with tick", n, 30);
    cfg_tmo = 0; cfg_pw = 3; cfg_dly = 5; pg_sel = 4'b0001; pg_in = 4'b0001;
    apply_reset(); tick = 0;
    step(100); chk("R10 delay frozen without tick", rst_out, 0);
    tick = 1;
    meas_pulse(100, s, w); chk("R10 delay finishes with tick", s, 5);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_poweron();
    t_pgdrop();
    t_width();
    t_wd_pin();
    t_init();
    t_wd_reset();
    t_disable();
    t_tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule